// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Main Divider

This block is the main counter of a fractional-N frequency synthesizer. It is clocked by the output of an external dual-modulus prescaler. That prescaler divides the oscillator by P when `mod_ctl` is low and by P+1 when `mod_ctl` is high. Each divider cycle lasts M prescaler clocks. In the first S of those clocks the block holds `mod_ctl` high, and it raises `div_pulse` on the last clock, which feeds the phase detector. One divider cycle therefore spans P·M + S oscillator periods.

S is the swallow count A, plus one when a first-order fractional accumulator carries. The fractional modulus is 2^k, with k from 0 to 5. On every divider-cycle boundary the accumulator adds the numerator F modulo 2^k. A carry from that addition gives the divider cycle that is starting one extra swallow clock. Over any 2^k consecutive divider cycles this adds exactly F extra oscillator periods, so the average ratio is P·M + A + F/2^k. This allows a comparison frequency up to 2^k times the channel spacing.

A three-state machine sequences each cycle:
- `ST_IDLE` is entered only by reset.
- Leaving `ST_IDLE` on the first clock edge is a boundary, and the machine goes to `ST_SWALLOW` or `ST_MAIN`.
- `ST_SWALLOW` moves to `ST_MAIN` once S swallow clocks have elapsed.
- On the last clock of a cycle, either state takes the boundary transition into `ST_SWALLOW` (new S > 0) or `ST_MAIN` (new S = 0).

The programming word is sampled only at boundaries.

Top module: `fracn_main_div`

## Requirements
- R1: While `rst_n` is low, `mod_ctl` and `div_pulse` are low and the accumulator is cleared. The first divider cycle begins on the first clock edge after release, using the word present at that edge.
- R2: `div_pulse` is high for exactly one prescaler clock, the last one of each divider cycle, and a divider cycle lasts Meff = max(`prog_m`, 1) clocks.
- R3: `mod_ctl` is high for the first S clocks of a divider cycle and low for the rest, with no re-rise inside the cycle, where S = min(A + c, Meff) and c is the accumulator carry (0 or 1).
- R4: With k = 0, every divider cycle spans exactly P·Meff + A oscillator periods, where P is the prescaler's low modulus (32 by default).
- R5: With a fixed word, any 2^k consecutive divider cycles span exactly 2^k·(P·M + A) + F oscillator periods.
- R6: After reset the accumulator starts at 0, so divider cycle i (counting from 0) carries exactly when floor((i+1)·F/2^k) > floor(i·F/2^k).
- R7: A change of `prog_m`, `prog_a`, `prog_f` or `prog_k` in the middle of a divider cycle leaves that cycle's length and swallow count unchanged. It takes effect from the next cycle.
- R8: Bits of `prog_f` at positions k and above are ignored. A `prog_k` value above 5 (that is 6 or 7) acts as 5.
- R9: A `prog_m` of 0 acts as 1. When A + c exceeds Meff, every clock of the cycle is a swallow clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_m | input | M_W (9) | Main count M |
| prog_a | input | A_W (5) | Swallow count A |
| prog_f | input | FRAC_W (5) | Fractional numerator F |
| prog_k | input | 3 | Denominator select k, modulus 2^k |
| mod_ctl | output | 1 | High: prescaler divides by P+1 |
| div_pulse | output | 1 | One-clock pulse at the end of each divider cycle |

## Verification
The bound checker watches the cycle shape on every clock:
- the spacing between pulses matches the main count in force;
- the number of high `mod_ctl` clocks in a cycle equals the swallow count loaded for it, and `mod_ctl` never rises again once it has fallen within a cycle;
- the latched main count never moves except at a boundary;
- the swallow count never exceeds the main count.

What the checker cannot see is arithmetic over many cycles. The exact oscillator-period totals over 2^k-cycle windows, the first-order carry placement after reset, masking of the numerator, clamping of the denominator select, and the cycle in which a new word starts to apply are shown only by the bench's directed scenarios. The bench rebuilds these totals from the two output pins.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } div_state_t;

endpackage

// File: rtl/fracn_word_reg.sv
// Sanitizes the programming inputs and holds the main count in force.
module fracn_word_reg #(
    parameter int M_W    = 9,
    parameter int A_W    = 5,
    parameter int FRAC_W = 5,
    parameter int K_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [M_W-1:0]    raw_m,
    input  logic [A_W-1:0]    raw_a,
    input  logic [FRAC_W-1:0] raw_f,
    input  logic [K_W-1:0]    raw_k,
    output logic [M_W-1:0]    nxt_m,
    output logic [A_W-1:0]    nxt_a,
    output logic [FRAC_W-1:0] nxt_f,
    output logic [K_W-1:0]    nxt_k,
    output logic [M_W-1:0]    cur_m
);

    localparam logic [K_W-1:0] K_MAX = K_W'(FRAC_W);

    logic [FRAC_W-1:0] fmask;

    always_comb begin
        nxt_m = (raw_m == '0) ? M_W'(1) : raw_m;
        nxt_a = raw_a;
        nxt_k = (raw_k > K_MAX) ? K_MAX : raw_k;
        fmask = {FRAC_W{1'b1}} >> (K_MAX - nxt_k);
        nxt_f = raw_f & fmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_m <= M_W'(1);
        end else if (load) begin
            cur_m <= nxt_m;
        end
    end

endmodule

// File: rtl/fracn_frac_acc.sv
// First-order accumulator modulo 2^k; carry is combinational for the step.
module fracn_frac_acc #(
    parameter int FRAC_W = 5,
    parameter int K_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    input  logic [K_W-1:0]    ksel,
    output logic              carry
);

    localparam logic [K_W-1:0] K_MAX = K_W'(FRAC_W);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_d;
    logic [FRAC_W-1:0] fmask;
    logic [FRAC_W:0]   sum;

    always_comb begin
        fmask = {FRAC_W{1'b1}} >> (K_MAX - ksel);
        sum   = {1'b0, acc_q & fmask} + {1'b0, frac};
        carry = |(sum & ~{1'b0, fmask});
        acc_d = sum[FRAC_W-1:0] & fmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/fracn_cycle_fsm.sv
// Sequences one divider cycle: swallow phase, main phase, boundary.
module fracn_cycle_fsm
    import fracn_div_pkg::*;
#(
    parameter int M_W = 9,
    parameter int A_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] cur_m,
    input  logic [M_W-1:0] nxt_m,
    input  logic [A_W-1:0] nxt_a,
    input  logic           carry,
    output logic           mod_ctl,
    output logic           div_pulse,
    output logic           boundary,
    output logic [M_W:0]   swal_q
);

    localparam int CW = M_W + 1;

    div_state_t     state_q, state_d;
    logic [M_W-1:0] cnt_q, cnt_d;
    logic [CW-1:0]  swal_d;
    logic [CW-1:0]  swal_raw;
    logic [CW-1:0]  swal_new;
    logic           last;
    div_state_t     entry_st;

    always_comb begin
        swal_raw = CW'(nxt_a) + CW'(carry);
        swal_new = (swal_raw > CW'(nxt_m)) ? CW'(nxt_m) : swal_raw;
        entry_st = (swal_new != '0) ? ST_SWALLOW : ST_MAIN;
        last     = (cnt_q == cur_m - M_W'(1));
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        swal_d   = swal_q;
        boundary = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                boundary = 1'b1;
                cnt_d    = '0;
                swal_d   = swal_new;
                state_d  = entry_st;
            end
            ST_SWALLOW: begin
                if (last) begin
                    boundary = 1'b1;
                    cnt_d    = '0;
                    swal_d   = swal_new;
                    state_d  = entry_st;
                end else begin
                    cnt_d = cnt_q + M_W'(1);
                    if ({1'b0, cnt_q} + CW'(1) == swal_q) begin
                        state_d = ST_MAIN;
                    end
                end
            end
            ST_MAIN: begin
                if (last) begin
                    boundary = 1'b1;
                    cnt_d    = '0;
                    swal_d   = swal_new;
                    state_d  = entry_st;
                end else begin
                    cnt_d = cnt_q + M_W'(1);
                end
            end
            default: begin
                cnt_d   = '0;
                swal_d  = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            swal_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            swal_q  <= swal_d;
        end
    end

    // outputs
    always_comb begin
        mod_ctl   = 1'b0;
        div_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mod_ctl   = 1'b0;
                div_pulse = 1'b0;
            end
            ST_SWALLOW: begin
                mod_ctl   = 1'b1;
                div_pulse = last;
            end
            ST_MAIN: begin
                mod_ctl   = 1'b0;
                div_pulse = last;
            end
            default: begin
                mod_ctl   = 1'b0;
                div_pulse = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div #(
    parameter int M_W    = 9,
    parameter int A_W    = 5,
    parameter int FRAC_W = 5,
    localparam int K_W   = $clog2(FRAC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [M_W-1:0]    prog_m,
    input  logic [A_W-1:0]    prog_a,
    input  logic [FRAC_W-1:0] prog_f,
    input  logic [K_W-1:0]    prog_k,
    output logic              mod_ctl,
    output logic              div_pulse
);

    logic [M_W-1:0]    nxt_m;
    logic [A_W-1:0]    nxt_a;
    logic [FRAC_W-1:0] nxt_f;
    logic [K_W-1:0]    nxt_k;
    logic [M_W-1:0]    cur_m;
    logic              carry;
    logic              boundary;
    logic [M_W:0]      swal_q;

    fracn_word_reg #(
        .M_W(M_W), .A_W(A_W), .FRAC_W(FRAC_W), .K_W(K_W)
    ) u_word (
        .clk(clk), .rst_n(rst_n), .load(boundary),
        .raw_m(prog_m), .raw_a(prog_a), .raw_f(prog_f), .raw_k(prog_k),
        .nxt_m(nxt_m), .nxt_a(nxt_a), .nxt_f(nxt_f), .nxt_k(nxt_k),
        .cur_m(cur_m)
    );

    fracn_frac_acc #(
        .FRAC_W(FRAC_W), .K_W(K_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .step(boundary),
        .frac(nxt_f), .ksel(nxt_k), .carry(carry)
    );

    fracn_cycle_fsm #(
        .M_W(M_W), .A_W(A_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cur_m(cur_m), .nxt_m(nxt_m), .nxt_a(nxt_a), .carry(carry),
        .mod_ctl(mod_ctl), .div_pulse(div_pulse),
        .boundary(boundary), .swal_q(swal_q)
    );

endmodule

// File: rtl/fracn_main_div_chk.sv
module fracn_main_div_chk #(
    parameter int M_W = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mod_ctl,
    input logic           div_pulse,
    input logic [M_W-1:0] cur_m,
    input logic [M_W:0]   swal_q
);

    logic         run;
    logic         seen;
    logic [M_W:0] gap;
    logic [M_W:0] nmod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            seen <= 1'b0;
            gap  <= '0;
            nmod <= '0;
        end else begin
            run <= 1'b1;
            if (div_pulse) begin
                seen <= 1'b1;
                gap  <= '0;
                nmod <= '0;
            end else begin
                gap  <= gap + 1'b1;
                nmod <= nmod + {{M_W{1'b0}}, mod_ctl};
            end
        end
    end

    // R1: outputs quiet in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!mod_ctl && !div_pulse)
                else $error("R1 outputs active during reset");
        end
    end

    a_r2_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && div_pulse) |-> (gap == {1'b0, cur_m} - 1'b1))
        else $error("R2 pulse spacing differs from main count");

    a_r3_swallow_total: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (nmod + {{M_W{1'b0}}, mod_ctl} == swal_q))
        else $error("R3 swallow clocks differ from loaded count");

    a_r3_no_rerise: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !mod_ctl && !div_pulse) |=> !mod_ctl)
        else $error("R3 modulus control re-rose inside a cycle");

    a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !div_pulse) |=> $stable(cur_m))
        else $error("R7 main count changed mid-cycle");

    a_r9_swallow_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (swal_q <= {1'b0, cur_m}))
        else $error("R9 swallow count above main count");

endmodule

bind fracn_main_div fracn_main_div_chk #(.M_W(M_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mod_ctl(mod_ctl), .div_pulse(div_pulse),
    .cur_m(cur_m), .swal_q(swal_q)
);

// File: tb/fracn_main_div_bench.sv
module fracn_main_div_bench;

    localparam int M_W    = 9;
    localparam int A_W    = 5;
    localparam int FRAC_W = 5;
    localparam int K_W    = 3;
    localparam int P      = 32;
    localparam int LOGN   = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [M_W-1:0]    prog_m = '0;
    logic [A_W-1:0]    prog_a = '0;
    logic [FRAC_W-1:0] prog_f = '0;
    logic [K_W-1:0]    prog_k = '0;
    logic              mod_ctl;
    logic              div_pulse;

    always #2 clk = ~clk;

    fracn_main_div #(.M_W(M_W), .A_W(A_W), .FRAC_W(FRAC_W)) u_fracn_main_div (
        .clk(clk), .rst_n(rst_n),
        .prog_m(prog_m), .prog_a(prog_a), .prog_f(prog_f), .prog_k(prog_k),
        .mod_ctl(mod_ctl), .div_pulse(div_pulse)
    );

    int checks = 0;
    int errors = 0;

    // per-cycle log built from the output pins only
    int idx = 0;
    int n_clk, n_sw, n_tot;
    bit went_low, shape_bad;
    int log_len [LOGN];
    int log_sw  [LOGN];
    int log_tot [LOGN];
    bit log_bad [LOGN];

    always @(negedge clk) begin
        if (!rst_n) begin
            idx = 0; n_clk = 0; n_sw = 0; n_tot = 0;
            went_low = 1'b0; shape_bad = 1'b0;
        end else begin
            n_clk++;
            n_tot += P + int'(mod_ctl);
            if (mod_ctl) begin
                n_sw++;
                if (went_low) shape_bad = 1'b1;
            end else begin
                went_low = 1'b1;
            end
            if (div_pulse) begin
                if (idx < LOGN) begin
                    log_len[idx] = n_clk;
                    log_sw[idx]  = n_sw;
                    log_tot[idx] = n_tot;
                    log_bad[idx] = shape_bad;
                end
                idx++;
                n_clk = 0; n_sw = 0; n_tot = 0;
                went_low = 1'b0; shape_bad = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_word(input int m, input int a, input int f, input int k);
        prog_m = M_W'(m);
        prog_a = A_W'(a);
        prog_f = FRAC_W'(f);
        prog_k = K_W'(k);
    endtask

    task automatic do_reset(input int m, input int a, input int f, input int k);
        @(negedge clk);
        #1 rst_n = 1'b0;
        set_word(m, a, f, k);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", "mod_ctl in reset", int'(mod_ctl), 0);
            chk("R1", "div_pulse in reset", int'(div_pulse), 0);
        end
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_idx(input int n);
        while (idx < n) @(negedge clk);
        #1;
    endtask

    function automatic int win_sum(input int s, input int n);
        int t = 0;
        for (int i = s; i < s + n; i++) t += log_tot[i];
        return t;
    endfunction

    task automatic t_reset_start();
        do_reset(5, 2, 0, 0);
        wait_idx(3);
        chk("R1", "first cycle length", log_len[0], 5);
        chk("R2", "cycle 1 length", log_len[1], 5);
        chk("R2", "cycle 2 length", log_len[2], 5);
        chk("R3", "cycle 0 swallow", log_sw[0], 2);
        chk("R3", "cycle 1 shape", int'(log_bad[1]), 0);
    endtask

    task automatic t_integer();
        do_reset(10, 3, 0, 0);
        wait_idx(4);
        for (int i = 0; i < 4; i++) begin
            chk("R4", "integer cycle total", log_tot[i], P * 10 + 3);
            chk("R2", "integer cycle length", log_len[i], 10);
        end
        do_reset(10, 3, 7, 0);
        wait_idx(3);
        chk("R4", "k=0 ignores F", log_tot[2], P * 10 + 3);
    endtask

    task automatic t_window();
        do_reset(20, 7, 5, 3);
        wait_idx(20);
        chk("R5", "window 8 from 0", win_sum(0, 8), 8 * (P * 20 + 7) + 5);
        chk("R5", "window 8 from 3", win_sum(3, 8), 8 * (P * 20 + 7) + 5);
        chk("R5", "window 8 from 9", win_sum(9, 8), 8 * (P * 20 + 7) + 5);
        do_reset(8, 4, 31, 5);
        wait_idx(40);
        chk("R5", "window 32 from 0", win_sum(0, 32), 32 * (P * 8 + 4) + 31);
        chk("R5", "window 32 from 5", win_sum(5, 32), 32 * (P * 8 + 4) + 31);
    endtask

    task automatic t_pattern();
        do_reset(6, 1, 3, 3);
        wait_idx(9);
        for (int i = 0; i < 8; i++) begin
            int c = ((i + 1) * 3) / 8 - (i * 3) / 8;
            chk("R6", "carry placement swallow", log_sw[i], 1 + c);
            chk("R3", "carry cycle shape", int'(log_bad[i]), 0);
        end
    endtask

    task automatic t_boundary();
        int c0;
        do_reset(12, 2, 0, 0);
        wait_idx(1);
        repeat (3) @(negedge clk);
        #1;
        c0 = idx;
        set_word(7, 5, 0, 0);
        wait_idx(c0 + 3);
        chk("R7", "in-flight cycle length", log_len[c0], 12);
        chk("R7", "in-flight cycle swallow", log_sw[c0], 2);
        chk("R7", "next cycle length", log_len[c0 + 1], 7);
        chk("R7", "next cycle swallow", log_sw[c0 + 1], 5);
        chk("R7", "later cycle total", log_tot[c0 + 2], P * 7 + 5);
    endtask

    task automatic t_ignore();
        do_reset(9, 2, 5'b10111, 2);
        wait_idx(10);
        chk("R8", "F high bits ignored", win_sum(1, 4), 4 * (P * 9 + 2) + 3);
        do_reset(3, 1, 1, 7);
        wait_idx(70);
        chk("R8", "k=7 acts as 5 window 0", win_sum(0, 32), 32 * (P * 3 + 1) + 1);
        chk("R8", "k=7 acts as 5 window 33", win_sum(33, 32), 32 * (P * 3 + 1) + 1);
    endtask

    task automatic t_clamp();
        do_reset(0, 0, 0, 0);
        wait_idx(5);
        for (int i = 0; i < 4; i++) begin
            chk("R9", "M=0 cycle length", log_len[i], 1);
            chk("R9", "M=0 cycle total", log_tot[i], P);
        end
        do_reset(4, 4, 1, 1);
        wait_idx(5);
        for (int i = 0; i < 4; i++) begin
            chk("R9", "A+c clamp swallow", log_sw[i], 4);
            chk("R9", "A+c clamp total", log_tot[i], P * 4 + 4);
        end
    endtask

    initial begin
        t_reset_start();
        t_integer();
        t_window();
        t_pattern();
        t_boundary();
        t_ignore();
        t_clamp();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule